// File: doc/BRIEF.md
# Dual-Channel Disk Register Address Decoder

This block sits between a programmed-IO host port and four disk drive slots, two per channel. It compares every host address with five windows. Each window has a programmable base and a fixed size, set by a parameter. The five windows are the command and control blocks of channel 0, the command and control blocks of channel 1, and one shared window of bus-master registers. From the matching window the block derives the channel, the block type and the offset inside the window, and it drives these onto decode outputs combinationally.

For each channel the block keeps a device-select bit. It updates this bit from byte writes to the drive-select register of that channel's command block. With this bit it forms a drive index from 0 to 3. It forwards legal command-block and control-block accesses to a single drive port, registered and with a ready handshake. A 32-bit access to the data port becomes two 16-bit drive beats. Accesses to the bus-master window are acknowledged without a drive transfer, so a neighbouring register file can act on the decode outputs. The block keeps one access outstanding at a time.

Top module: `ide_pio_decoder`

## Requirements
- R1: Windows are matched in fixed priority: channel-0 command (bar index 0), channel-0 control (1), channel-1 command (2), channel-1 control (3), bus-master (4). An enabled access that hits no window completes with `rsp_err_o`=1. `dec_blk_o` encodes 0 command, 1 control, 2 bus-master, 3 no hit.
- R2: In the bus-master window, offsets below `BM_SPLIT` decode to channel 0 and the other offsets decode to channel 1. A bus-master access completes without error, returns data 0, and makes no drive transfer.
- R3: A byte write to command-block offset 6 loads bit 4 of the write data into that channel's device bit. The write itself is still forwarded to the drive. The drive index is 2×channel + device bit, and the select write already uses the new bit.
- R4: While `io_en_i` is 0, every access completes with no error and data 0. It makes no drive transfer and changes no device bit.
- R5: Command-block offset 0 is the data port. It accepts size 1 (16-bit) and size 2 (32-bit). A 32-bit access is sent as two 16-bit beats at the same offset, with the low half first.
- R6: Every other command-block or control-block offset accepts only size 0 (byte). A disallowed size completes with `rsp_err_o`=1 and makes no drive transfer.
- R7: A window whose base is zero matches nothing. A `bar_wr_i` with nonzero data replaces the base selected by `bar_idx_i`. A `bar_wr_i` with zero data leaves that base unchanged.
- R8: When `drv_present_i` is 0 at the computed index, reads return 0xFFFFFFFF and writes are dropped. Neither makes a drive transfer, and neither raises an error.
- R9: An access without a drive transfer raises `rsp_valid_o` in the cycle after it is accepted. A drive request appears in the cycle after acceptance and holds its fields until `drv_ready_i`. No new access is accepted while a request or response is pending.
- R10: Read data is zero-extended for a byte (low 8 bits of the drive data) and for a 16-bit access. A 32-bit read returns {second beat, first beat}. Writes return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| io_en_i | input | 1 | IO-space enable from configuration |
| bar_wr_i | input | 1 | Base register write strobe |
| bar_idx_i | input | 3 | Window selected by the base write (0..4) |
| bar_data_i | input | AW | New base value |
| req_valid_i | input | 1 | Host access valid |
| req_ready_o | output | 1 | Host access accepted this cycle when valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Host address |
| req_size_i | input | 2 | 0 byte, 1 16-bit, 2 32-bit, 3 illegal |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_err_o | output | 1 | Completion carries an error |
| rsp_rdata_o | output | 32 | Read data of the completion |
| dec_hit_o | output | 1 | Address hits a window |
| dec_blk_o | output | 2 | Block type of the hit |
| dec_chan_o | output | 1 | Channel of the hit |
| dec_off_o | output | OW | Offset within the window |
| drv_present_i | input | 4 | Drive present per index |
| drv_valid_o | output | 1 | Drive request valid |
| drv_ready_i | input | 1 | Drive accepts the beat |
| drv_write_o | output | 1 | Drive beat is a write |
| drv_idx_o | output | 2 | Target drive index |
| drv_ctrl_o | output | 1 | 1 = control block, 0 = command block |
| drv_off_o | output | OW | Register offset at the drive |
| drv_wdata_o | output | 16 | Write data of the beat |
| drv_rdata_i | input | 16 | Read data of the beat |

## Verification
The decode outputs follow `req_addr_i` within the same cycle, so they are sampled a short delay after the address changes at a falling edge. A completion without a drive transfer is due exactly one cycle after the accepting edge. The scoreboard records that edge and requires the pulse at the next falling edge. Drive beats complete at the edge where ready is high, and the completion follows one cycle after the last beat. For that reason drive-bound completions are matched in order rather than at a fixed cycle, and the drive model checks each beat's fields at the cycle it grants ready, including under stalls.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;
  typedef enum logic [1:0] {BLK_CMD = 2'd0, BLK_CTRL = 2'd1, BLK_BM = 2'd2, BLK_NONE = 2'd3} blk_e;
  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_X = 2'd3} size_e;
  localparam int unsigned NUM_WIN = 5;
  localparam int unsigned DATA_OFF = 0;
  localparam int unsigned SEL_OFF  = 6;
  localparam int unsigned DEV_BIT  = 4;
endpackage

// File: rtl/ide_win_match.sv
module ide_win_match #(
  parameter int unsigned AW   = 16,
  parameter int unsigned OW   = 4,
  parameter int unsigned SIZE = 8
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] addr_i,
  output logic          hit_o,
  output logic [OW-1:0] off_o
);
  logic [AW:0] lim;
  logic [AW-1:0] diff;
  assign lim   = {1'b0, base_i} + (AW+1)'(SIZE);
  assign diff  = addr_i - base_i;
  assign hit_o = (base_i != '0) && (addr_i >= base_i) && ({1'b0, addr_i} < lim);
  assign off_o = diff[OW-1:0];
endmodule

// File: rtl/ide_dev_sel.sv
module ide_dev_sel #(
  parameter int unsigned NCH = 2,
  localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           set_i,
  input  logic [CW-1:0]  chan_i,
  input  logic           bit_i,
  output logic [NCH-1:0] dev_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    dev_o <= '0;
    else if (set_i) dev_o[chan_i] <= bit_i;
  end

  // R3: the latched bit follows the select write of its channel
  a_r3_dev_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> dev_o[$past(chan_i)] == $past(bit_i));
endmodule

// File: rtl/ide_drv_seq.sv
module ide_drv_seq
  import ide_dec_pkg::*;
#(
  parameter int unsigned OW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          wr_i,
  input  logic [1:0]    size_i,
  input  logic [1:0]    idx_i,
  input  logic          ctrl_i,
  input  logic [OW-1:0] off_i,
  input  logic [31:0]   wdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [31:0]   rdata_o,
  output logic          drv_valid_o,
  input  logic          drv_ready_i,
  output logic          drv_write_o,
  output logic [1:0]    drv_idx_o,
  output logic          drv_ctrl_o,
  output logic [OW-1:0] drv_off_o,
  output logic [15:0]   drv_wdata_o,
  input  logic [15:0]   drv_rdata_i
);
  logic          busy_q, beat_q, last;
  logic [1:0]    size_q;
  logic [31:0]   wdata_q;
  logic [15:0]   lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; beat_q <= 1'b0; size_q <= '0; wdata_q <= '0; lo_q <= '0;
      drv_write_o <= 1'b0; drv_idx_o <= '0; drv_ctrl_o <= 1'b0; drv_off_o <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1; beat_q <= 1'b0; size_q <= size_i; wdata_q <= wdata_i;
      drv_write_o <= wr_i; drv_idx_o <= idx_i; drv_ctrl_o <= ctrl_i; drv_off_o <= off_i;
    end else if (busy_q && drv_ready_i) begin
      if (last) busy_q <= 1'b0;
      else begin
        beat_q <= 1'b1;
        lo_q   <= drv_rdata_i;
      end
    end
  end

  assign last        = (size_q != SZ_W) || beat_q;
  assign busy_o      = busy_q;
  assign drv_valid_o = busy_q;
  assign done_o      = busy_q && drv_ready_i && last;
  assign drv_wdata_o = beat_q ? wdata_q[31:16] : wdata_q[15:0];

  always_comb begin
    case (size_q)
      SZ_B:    rdata_o = {24'd0, drv_rdata_i[7:0]};
      SZ_W:    rdata_o = {drv_rdata_i, lo_q};
      default: rdata_o = {16'd0, drv_rdata_i};
    endcase
  end

  // R9: a stalled beat keeps its fields
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_valid_o && !drv_ready_i |=> drv_valid_o && $stable(drv_wdata_o) &&
      $stable(drv_idx_o) && $stable(drv_off_o) && $stable(drv_write_o));
endmodule

// File: rtl/ide_pio_decoder.sv
module ide_pio_decoder
  import ide_dec_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned OW        = 4,
  parameter int unsigned CMD_SIZE  = 8,
  parameter int unsigned CTRL_SIZE = 4,
  parameter int unsigned BM_SIZE   = 16,
  parameter int unsigned BM_SPLIT  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          io_en_i,
  input  logic          bar_wr_i,
  input  logic [2:0]    bar_idx_i,
  input  logic [AW-1:0] bar_data_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [1:0]    req_size_i,
  input  logic [31:0]   req_wdata_i,
  output logic          rsp_valid_o,
  output logic          rsp_err_o,
  output logic [31:0]   rsp_rdata_o,
  output logic          dec_hit_o,
  output logic [1:0]    dec_blk_o,
  output logic          dec_chan_o,
  output logic [OW-1:0] dec_off_o,
  input  logic [3:0]    drv_present_i,
  output logic          drv_valid_o,
  input  logic          drv_ready_i,
  output logic          drv_write_o,
  output logic [1:0]    drv_idx_o,
  output logic          drv_ctrl_o,
  output logic [OW-1:0] drv_off_o,
  output logic [15:0]   drv_wdata_o,
  input  logic [15:0]   drv_rdata_i
);
  localparam int unsigned NW = NUM_WIN;
  localparam logic [2:0]  BM_W = 3'(NW - 1);

  logic [AW-1:0] base_q [NW];
  logic [NW-1:0] hit;
  logic [OW-1:0] off_w [NW];
  logic [2:0]    sel_w;
  logic          is_data, size_ok, sel_wr, dev_eff, present, fwd_blk;
  logic          acc, start, busy, done;
  logic [1:0]    idx;
  logic [1:0]    dev_q;
  logic [31:0]   seq_rdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NW; i++) base_q[i] <= '0;
    end else if (bar_wr_i && bar_data_i != '0 && bar_idx_i < 3'(NW)) begin
      base_q[bar_idx_i] <= bar_data_i;
    end
  end

  for (genvar w = 0; w < NW; w++) begin : g_win
    localparam int unsigned WSZ = (w == NW - 1) ? BM_SIZE : ((w % 2 == 1) ? CTRL_SIZE : CMD_SIZE);
    ide_win_match #(.AW(AW), .OW(OW), .SIZE(WSZ)) u_match (
      .base_i(base_q[w]), .addr_i(req_addr_i), .hit_o(hit[w]), .off_o(off_w[w])
    );
  end

  // lowest window index wins
  always_comb begin
    sel_w     = '0;
    dec_hit_o = 1'b0;
    for (int i = NW - 1; i >= 0; i--) begin
      if (hit[i]) begin
        dec_hit_o = 1'b1;
        sel_w     = 3'(i);
      end
    end
    dec_off_o = off_w[sel_w];
    if (!dec_hit_o)        dec_blk_o = BLK_NONE;
    else if (sel_w == BM_W) dec_blk_o = BLK_BM;
    else if (sel_w[0])     dec_blk_o = BLK_CTRL;
    else                   dec_blk_o = BLK_CMD;
    dec_chan_o = (sel_w == BM_W) ? (dec_off_o >= OW'(BM_SPLIT)) : sel_w[1];
  end

  assign fwd_blk = dec_hit_o && dec_blk_o != BLK_BM;
  assign is_data = dec_blk_o == BLK_CMD && dec_off_o == OW'(DATA_OFF);
  assign size_ok = is_data ? (req_size_i == SZ_H || req_size_i == SZ_W) : (req_size_i == SZ_B);
  assign sel_wr  = req_write_i && dec_blk_o == BLK_CMD && dec_off_o == OW'(SEL_OFF) &&
                   req_size_i == SZ_B;
  assign dev_eff = sel_wr ? req_wdata_i[DEV_BIT] : dev_q[dec_chan_o];
  assign idx     = {dec_chan_o, dev_eff};
  assign present = drv_present_i[idx];

  assign acc         = req_valid_i && req_ready_o;
  assign req_ready_o = !busy && !rsp_valid_o;
  assign start       = acc && io_en_i && fwd_blk && size_ok && present;

  ide_dev_sel #(.NCH(2)) u_dev (
    .clk_i, .rst_ni,
    .set_i (acc && io_en_i && dec_hit_o && sel_wr),
    .chan_i(dec_chan_o),
    .bit_i (req_wdata_i[DEV_BIT]),
    .dev_o (dev_q)
  );

  ide_drv_seq #(.OW(OW)) u_seq (
    .clk_i, .rst_ni,
    .start_i(start), .wr_i(req_write_i), .size_i(req_size_i), .idx_i(idx),
    .ctrl_i(dec_blk_o == BLK_CTRL), .off_i(dec_off_o), .wdata_i(req_wdata_i),
    .busy_o(busy), .done_o(done), .rdata_o(seq_rdata),
    .drv_valid_o, .drv_ready_i, .drv_write_o, .drv_idx_o, .drv_ctrl_o,
    .drv_off_o, .drv_wdata_o, .drv_rdata_i
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0; rsp_err_o <= 1'b0; rsp_rdata_o <= '0;
    end else if (acc && !start) begin
      rsp_valid_o <= 1'b1;
      rsp_err_o   <= io_en_i && (!dec_hit_o || (fwd_blk && !size_ok));
      rsp_rdata_o <= (io_en_i && fwd_blk && size_ok && !present && !req_write_i) ? '1 : '0;
    end else if (done) begin
      rsp_valid_o <= 1'b1;
      rsp_err_o   <= 1'b0;
      rsp_rdata_o <= drv_write_o ? '0 : seq_rdata;
    end else begin
      rsp_valid_o <= 1'b0;
    end
  end

  // R4: disabled IO completes quietly
  a_r4_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !io_en_i |=> rsp_valid_o && !rsp_err_o && rsp_rdata_o == '0 && !drv_valid_o);
  // R1: a miss completes with an error
  a_r1_miss_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && io_en_i && !dec_hit_o |=> rsp_valid_o && rsp_err_o);
  // R9: one access in flight
  a_r9_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_valid_o |-> !req_ready_o);
endmodule

// File: tb/ide_pio_decoder_bench.sv
module ide_pio_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_en = 1'b0;
  logic        bar_wr = 1'b0;
  logic [2:0]  bar_idx = '0;
  logic [15:0] bar_data = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  drv_present = 4'b0111;
  logic        drv_ready = 1'b0;
  logic [15:0] drv_rdata = '0;
  logic        req_ready, rsp_valid, rsp_err, dec_hit, dec_chan;
  logic [31:0] rsp_rdata;
  logic [1:0]  dec_blk, drv_idx;
  logic [3:0]  dec_off, drv_off;
  logic        drv_valid, drv_write, drv_ctrl;
  logic [15:0] drv_wdata;

  int n_chk = 0, n_err = 0, cyc = 0, dcnt = 0;
  bit stall = 1'b0, tog = 1'b0;

  bit          q_err[$];
  logic [31:0] q_rd[$];
  bit          q_lat[$];
  int          q_cyc[$];
  string       q_tag[$];
  bit          d_wr[$];
  logic [1:0]  d_idx[$];
  bit          d_ctrl[$];
  logic [3:0]  d_off[$];
  logic [15:0] d_wd[$];
  string       d_tag[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  ide_pio_decoder u_ide_pio_decoder (
    .clk_i(clk), .rst_ni(rst_n), .io_en_i(io_en),
    .bar_wr_i(bar_wr), .bar_idx_i(bar_idx), .bar_data_i(bar_data),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_size_i(req_size), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
    .dec_hit_o(dec_hit), .dec_blk_o(dec_blk), .dec_chan_o(dec_chan), .dec_off_o(dec_off),
    .drv_present_i(drv_present), .drv_valid_o(drv_valid), .drv_ready_i(drv_ready),
    .drv_write_o(drv_write), .drv_idx_o(drv_idx), .drv_ctrl_o(drv_ctrl),
    .drv_off_o(drv_off), .drv_wdata_o(drv_wdata), .drv_rdata_i(drv_rdata)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic exp_drv(string tag, bit wr, logic [1:0] idx, bit ctrl, logic [3:0] off,
                         logic [15:0] wd);
    d_wr.push_back(wr); d_idx.push_back(idx); d_ctrl.push_back(ctrl);
    d_off.push_back(off); d_wd.push_back(wd); d_tag.push_back(tag);
  endtask

  task automatic do_acc(string tag, bit wr, logic [15:0] addr, logic [1:0] sz,
                        logic [31:0] wd, bit eerr, logic [31:0] erd, bit lat);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    q_err.push_back(eerr); q_rd.push_back(erd); q_lat.push_back(lat);
    q_cyc.push_back(cyc + 1); q_tag.push_back(tag);
    req_write = wr; req_addr = addr; req_size = sz; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (q_err.size() != 0) @(negedge clk);
  endtask

  task automatic set_bar(logic [2:0] i, logic [15:0] v);
    @(negedge clk);
    bar_wr = 1'b1; bar_idx = i; bar_data = v;
    @(negedge clk);
    bar_wr = 1'b0;
  endtask

  task automatic dchk(string tag, logic [15:0] addr, logic [1:0] blk, bit ch, logic [3:0] off);
    @(negedge clk);
    req_addr = addr;
    #1;
    chk(dec_blk == blk, {tag, " blk"}, 32'(dec_blk), 32'(blk));
    if (blk != 2'd3) begin
      chk(dec_chan == ch, {tag, " chan"}, 32'(dec_chan), 32'(ch));
      chk(dec_off == off, {tag, " off"}, 32'(dec_off), 32'(off));
    end
  endtask

  // response monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rsp_valid) begin
        if (q_err.size() == 0) chk(1'b0, "R9 unexpected response", 32'(rsp_valid), 32'd0);
        else begin
          automatic bit    e   = q_err.pop_front();
          automatic logic [31:0] r = q_rd.pop_front();
          automatic bit    l   = q_lat.pop_front();
          automatic int    c   = q_cyc.pop_front();
          automatic string t   = q_tag.pop_front();
          chk(rsp_err == e, {t, " err"}, 32'(rsp_err), 32'(e));
          chk(rsp_rdata == r, {t, " rdata"}, rsp_rdata, r);
          if (l) chk(cyc == c, "R9 response latency", 32'(cyc), 32'(c));
        end
      end
    end
  end

  // drive model
  initial begin
    forever begin
      @(negedge clk);
      if (drv_valid && !(stall && tog)) begin
        drv_ready = 1'b1;
        drv_rdata = 16'h1000 + dcnt[15:0];
        dcnt++;
        if (d_wr.size() == 0) chk(1'b0, "R9 unexpected drive beat", 32'(drv_idx), 32'd0);
        else begin
          automatic bit    w = d_wr.pop_front();
          automatic logic [1:0] x = d_idx.pop_front();
          automatic bit    k = d_ctrl.pop_front();
          automatic logic [3:0] o = d_off.pop_front();
          automatic logic [15:0] v = d_wd.pop_front();
          automatic string t = d_tag.pop_front();
          chk(drv_write == w, {t, " drv write"}, 32'(drv_write), 32'(w));
          chk(drv_idx == x, {t, " drv idx"}, 32'(drv_idx), 32'(x));
          chk(drv_ctrl == k, {t, " drv ctrl"}, 32'(drv_ctrl), 32'(k));
          chk(drv_off == o, {t, " drv off"}, 32'(drv_off), 32'(o));
          if (w) chk(drv_wdata == v, {t, " drv wdata"}, 32'(drv_wdata), 32'(v));
        end
      end else drv_ready = 1'b0;
      tog = !tog;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'(cyc), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [15:0] b0, b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 reset ready", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R9 reset rsp", 32'(rsp_valid), 32'd0);
    chk(drv_valid == 1'b0, "R9 reset drv", 32'(drv_valid), 32'd0);
    io_en = 1'b1;

    // R7: unconfigured windows miss
    do_acc("R7 unconfigured miss", 1'b0, 16'h01F7, 2'd0, 0, 1'b1, 0, 1'b1);
    set_bar(0, 16'h01F0); set_bar(1, 16'h03F4); set_bar(2, 16'h0170);
    set_bar(3, 16'h0374); set_bar(4, 16'hC000);
    set_bar(0, 16'h0000);
    dchk("R7 zero base write ignored", 16'h01F2, 2'd0, 1'b0, 4'd2);

    // R1: priority with overlap
    set_bar(3, 16'h01F0);
    dchk("R1 overlap prefers cmd0", 16'h01F2, 2'd0, 1'b0, 4'd2);
    set_bar(3, 16'h0374);
    dchk("R1 ctrl1 decode", 16'h0376, 2'd1, 1'b1, 4'd2);
    dchk("R1 ctrl0 decode", 16'h03F5, 2'd1, 1'b0, 4'd1);
    dchk("R1 miss past bm", 16'hC010, 2'd3, 1'b0, 4'd0);
    do_acc("R1 miss error", 1'b1, 16'h2000, 2'd0, 0, 1'b1, 0, 1'b1);

    // R2: bus-master split
    dchk("R2 bm low", 16'hC007, 2'd2, 1'b0, 4'd7);
    dchk("R2 bm split", 16'hC008, 2'd2, 1'b1, 4'd8);
    dchk("R2 bm top", 16'hC00F, 2'd2, 1'b1, 4'd15);
    do_acc("R2 bm access", 1'b0, 16'hC002, 2'd0, 0, 1'b0, 0, 1'b1);

    // R6: size rules
    do_acc("R6 half to status", 1'b0, 16'h01F1, 2'd1, 0, 1'b1, 0, 1'b1);
    do_acc("R6 word to ctrl", 1'b1, 16'h03F6, 2'd2, 0, 1'b1, 0, 1'b1);
    do_acc("R6 byte to data", 1'b0, 16'h01F0, 2'd0, 0, 1'b1, 0, 1'b1);

    // R5 and R10: split data port
    b0 = 16'h1000 + dcnt[15:0]; b1 = b0 + 16'd1;
    exp_drv("R5 word read lo", 1'b0, 2'd0, 1'b0, 4'd0, 0);
    exp_drv("R5 word read hi", 1'b0, 2'd0, 1'b0, 4'd0, 0);
    do_acc("R10 word read", 1'b0, 16'h01F0, 2'd2, 0, 1'b0, {b1, b0}, 1'b0);
    exp_drv("R5 word write lo", 1'b1, 2'd2, 1'b0, 4'd0, 16'hBEEF);
    exp_drv("R5 word write hi", 1'b1, 2'd2, 1'b0, 4'd0, 16'hDEAD);
    do_acc("R10 word write", 1'b1, 16'h0170, 2'd2, 32'hDEADBEEF, 1'b0, 0, 1'b0);
    b0 = 16'h1000 + dcnt[15:0];
    exp_drv("R10 byte read", 1'b0, 2'd0, 1'b0, 4'd7, 0);
    do_acc("R10 byte read", 1'b0, 16'h01F7, 2'd0, 0, 1'b0, {24'd0, b0[7:0]}, 1'b0);
    b0 = 16'h1000 + dcnt[15:0];
    exp_drv("R5 half read", 1'b0, 2'd2, 1'b0, 4'd0, 0);
    do_acc("R10 half read", 1'b0, 16'h0170, 2'd1, 0, 1'b0, {16'd0, b0}, 1'b0);
    b0 = 16'h1000 + dcnt[15:0];
    exp_drv("R1 ctrl forward", 1'b0, 2'd3 & 2'd2, 1'b1, 4'd2, 0);
    do_acc("R1 ctrl1 read", 1'b0, 16'h0376, 2'd0, 0, 1'b0, {24'd0, b0[7:0]}, 1'b0);

    // R3: drive select
    exp_drv("R3 select write forwarded", 1'b1, 2'd1, 1'b0, 4'd6, 16'h0010);
    do_acc("R3 select dev1", 1'b1, 16'h01F6, 2'd0, 32'h10, 1'b0, 0, 1'b0);
    b0 = 16'h1000 + dcnt[15:0];
    exp_drv("R3 read after select", 1'b0, 2'd1, 1'b0, 4'd2, 0);
    do_acc("R3 read dev1", 1'b0, 16'h01F2, 2'd0, 0, 1'b0, {24'd0, b0[7:0]}, 1'b0);
    exp_drv("R3 deselect forwarded", 1'b1, 2'd0, 1'b0, 4'd6, 16'h0000);
    do_acc("R3 select dev0", 1'b1, 16'h01F6, 2'd0, 32'h00, 1'b0, 0, 1'b0);

    // R8: absent drive 3
    do_acc("R8 select absent write dropped", 1'b1, 16'h0176, 2'd0, 32'h10, 1'b0, 0, 1'b1);
    do_acc("R8 absent byte read", 1'b0, 16'h0172, 2'd0, 0, 1'b0, 32'hFFFFFFFF, 1'b1);
    do_acc("R8 absent word read", 1'b0, 16'h0170, 2'd2, 0, 1'b0, 32'hFFFFFFFF, 1'b1);
    exp_drv("R3 chan1 back to dev0", 1'b1, 2'd2, 1'b0, 4'd6, 16'h0000);
    do_acc("R3 chan1 select dev0", 1'b1, 16'h0176, 2'd0, 32'h00, 1'b0, 0, 1'b0);

    // R4: IO disabled
    io_en = 1'b0;
    do_acc("R4 disabled select write", 1'b1, 16'h01F6, 2'd0, 32'h10, 1'b0, 0, 1'b1);
    do_acc("R4 disabled data read", 1'b0, 16'h01F0, 2'd2, 0, 1'b0, 0, 1'b1);
    do_acc("R4 disabled miss", 1'b0, 16'h2000, 2'd0, 0, 1'b0, 0, 1'b1);
    io_en = 1'b1;
    b0 = 16'h1000 + dcnt[15:0];
    exp_drv("R4 dev bit unchanged", 1'b0, 2'd0, 1'b0, 4'd2, 0);
    do_acc("R4 read after disabled select", 1'b0, 16'h01F2, 2'd0, 0, 1'b0, {24'd0, b0[7:0]}, 1'b0);

    // R9: stalls on the drive port
    stall = 1'b1;
    b0 = 16'h1000 + dcnt[15:0]; b1 = b0 + 16'd1;
    exp_drv("R9 stalled lo", 1'b0, 2'd0, 1'b0, 4'd0, 0);
    exp_drv("R9 stalled hi", 1'b0, 2'd0, 1'b0, 4'd0, 0);
    do_acc("R9 stalled word read", 1'b0, 16'h01F0, 2'd2, 0, 1'b0, {b1, b0}, 1'b0);
    exp_drv("R9 stalled write lo", 1'b1, 2'd0, 1'b0, 4'd0, 16'h5678);
    exp_drv("R9 stalled write hi", 1'b1, 2'd0, 1'b0, 4'd0, 16'h1234);
    do_acc("R9 stalled word write", 1'b1, 16'h01F0, 2'd2, 32'h12345678, 1'b0, 0, 1'b0);
    stall = 1'b0;

    repeat (4) @(negedge clk);
    chk(d_wr.size() == 0, "R9 drive beats outstanding", 32'(d_wr.size()), 32'd0);
    chk(q_err.size() == 0, "R9 responses outstanding", 32'(q_err.size()), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule